// File: doc/BRIEF.md
# XON/XOFF Software Flow Controller

This block sits between a UART receiver, the receive FIFO and a UART transmitter and performs automatic software flow control. Every received character is compared against four programmable flow characters: two resume characters (first and second XON) and two stop characters (first and second XOFF). A matched stop character raises a pause request towards the local transmitter, a matched resume character drops it, and matched flow characters are swallowed instead of being passed on to the receive FIFO. A sticky status vector records which flow characters and line breaks have been seen until software acknowledges it with a read strobe.

In the other direction the block watches the receive FIFO fill level. When the level climbs to a programmed halt threshold it asks the transmitter to insert a stop character; once the level has drained to a programmed resume threshold it asks for a resume character. Thresholds are programmed in units of eight FIFO words. A hysteresis flag guarantees that requests alternate between stop and resume, so a level that stays high or low never produces a second identical request. Two independent 2-bit selectors pick which character pair is matched on receive and which pair is sent.

Top module: `xonxoff_flow`

## Requirements
- R1: After reset txPause, injReq, fwdValid and specStat are all 0.
- R2: rxSel chooses the matched characters: 00 matches none, 01 matches only the second pair (xonB, xoffB), 10 only the first pair (xonA, xoffA), 11 all four; an unmatched character has no effect on txPause.
- R3: A matched stop character sets txPause one cycle after the rxValid cycle and a matched resume character clears it one cycle later; if a character matches both, the stop wins.
- R4: A received character that is not a matched flow character appears on fwdData with fwdValid one cycle after rxValid; a matched flow character produces no fwdValid.
- R5: specStat bit 0 = xonA seen, bit 1 = xonB, bit 2 = xoffA, bit 3 = xoffB, bit 4 = break (rxValid with rxBreak); bits are set one cycle after the character, stay set until statClr, and a set in the clearing cycle survives the clear.
- R6: With flowEn low no character is matched (all are forwarded, no flow status bits set), txPause is 0 from the next cycle and injReq is 0 from the next cycle.
- R7: levelCfg[3:0] is the halt threshold and levelCfg[7:4] the resume threshold, each times 8 words; a stop request starts the cycle after rxLevel >= halt*8, a resume request the cycle after rxLevel <= resume*8 once a stop has been requested.
- R8: txSel chooses the characters sent: 00 none and the hysteresis flag cleared, 01 the second pair, 10 the first pair, 11 both, as xoffA then xoffB for a stop and xonA then xonB for a resume.
- R9: injReq stays high with injData stable until a cycle with injAck; the next character of a pair, if any, is presented from the following cycle.
- R10: Stop and resume requests strictly alternate: while the level stays above the resume threshold after a stop, or below the halt threshold after a resume, no further request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flowEn | input | 1 | Master enable for software flow control |
| rxSel | input | 2 | Receive match selector |
| txSel | input | 2 | Transmit insertion selector |
| xonA | input | 8 | First resume character |
| xonB | input | 8 | Second resume character |
| xoffA | input | 8 | First stop character |
| xoffB | input | 8 | Second stop character |
| levelCfg | input | 8 | Resume threshold [7:4], halt threshold [3:0], units of 8 words |
| rxValid | input | 1 | Received character strobe |
| rxData | input | 8 | Received character |
| rxBreak | input | 1 | Break flag qualified by rxValid |
| rxLevel | input | 8 | Receive FIFO fill level, 0 to 128 |
| fwdValid | output | 1 | Character write strobe to receive FIFO |
| fwdData | output | 8 | Character forwarded to receive FIFO |
| txPause | output | 1 | Pause request to local transmitter |
| injReq | output | 1 | Request to insert a flow character |
| injData | output | 8 | Flow character to insert |
| injAck | input | 1 | Transmitter accepts injData |
| statClr | input | 1 | Read strobe clearing specStat |
| specStat | output | 5 | Sticky flow-character and break status |

## Verification
The bench builds the block with its default parameters: 8-bit characters, a 128-entry FIFO, 4-bit threshold fields and an 8-word unit. With those values every threshold product up to 120 words lies inside the drivable level range, so the halt and resume boundaries are hit exactly (level equal to threshold*8) as well as from both sides, and the full-FIFO level of 128 can be presented. Each selector value on both sides is exercised, including the two-character sequences of selector 11.

// File: rtl/xonxoff_flow_pkg.sv
package xonxoff_flow_pkg;

  // Datapath findings handed to the control
  typedef struct packed {
    logic xonHit;
    logic xoffHit;
    logic levelHigh;
    logic levelLow;
  } dp_flags_t;

  // Control strobes steering the datapath injection mux
  typedef struct packed {
    logic active;
    logic kindOn;
    logic pickFirst;
  } ctl_strobe_t;

  typedef enum logic [1:0] {
    INJ_IDLE   = 2'd0,
    INJ_FIRST  = 2'd1,
    INJ_SECOND = 2'd2
  } inj_state_e;

  localparam logic [1:0] SEL_NONE   = 2'b00;
  localparam logic [1:0] SEL_SECOND = 2'b01;
  localparam logic [1:0] SEL_FIRST  = 2'b10;
  localparam logic [1:0] SEL_BOTH   = 2'b11;

endpackage

// File: rtl/xonxoff_flow_dp.sv
module xonxoff_flow_dp
  import xonxoff_flow_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int LVL_W    = 8,
  parameter int THR_W    = 4,
  parameter int LVL_UNIT = 8,
  parameter int STAT_W   = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 flowEn,
  input  logic [1:0]           rxSel,
  input  logic [DATA_W-1:0]    xonA,
  input  logic [DATA_W-1:0]    xonB,
  input  logic [DATA_W-1:0]    xoffA,
  input  logic [DATA_W-1:0]    xoffB,
  input  logic [2*THR_W-1:0]   levelCfg,
  input  logic                 rxValid,
  input  logic [DATA_W-1:0]    rxData,
  input  logic                 rxBreak,
  input  logic [LVL_W-1:0]     rxLevel,
  input  logic                 statClr,
  input  ctl_strobe_t          ctl,
  output dp_flags_t            flags,
  output logic                 fwdValid,
  output logic [DATA_W-1:0]    fwdData,
  output logic [DATA_W-1:0]    injData,
  output logic [STAT_W-1:0]    specStat
);

  localparam int CMP_W = LVL_W + THR_W;

  logic useFirst, useSecond;
  logic hitXonA, hitXonB, hitXoffA, hitXoffB, anyHit;
  logic [STAT_W-1:0] setMask;
  logic [CMP_W-1:0] haltWords, resumeWords, levelExt;

  // Receive-side comparison, qualified by enable and pair selection
  assign useFirst  = flowEn && rxSel[1];
  assign useSecond = flowEn && rxSel[0];

  assign hitXonA  = rxValid && useFirst  && (rxData == xonA);
  assign hitXonB  = rxValid && useSecond && (rxData == xonB);
  assign hitXoffA = rxValid && useFirst  && (rxData == xoffA);
  assign hitXoffB = rxValid && useSecond && (rxData == xoffB);
  assign anyHit   = hitXonA || hitXonB || hitXoffA || hitXoffB;

  // Threshold products in FIFO words
  assign haltWords   = CMP_W'(levelCfg[THR_W-1:0]) * CMP_W'(LVL_UNIT);
  assign resumeWords = CMP_W'(levelCfg[2*THR_W-1:THR_W]) * CMP_W'(LVL_UNIT);
  assign levelExt    = CMP_W'(rxLevel);

  always_comb begin
    flags.xonHit    = hitXonA || hitXonB;
    flags.xoffHit   = hitXoffA || hitXoffB;
    flags.levelHigh = (levelExt >= haltWords);
    flags.levelLow  = (levelExt <= resumeWords);
  end

  // Forwarding register towards the receive FIFO
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fwdValid <= 1'b0;
      fwdData  <= '0;
    end else begin
      fwdValid <= rxValid && !anyHit;
      if (rxValid) fwdData <= rxData;
    end
  end

  // Sticky status; a new event in the clearing cycle survives
  always_comb begin
    setMask    = '0;
    setMask[0] = hitXonA;
    setMask[1] = hitXonB;
    setMask[2] = hitXoffA;
    setMask[3] = hitXoffB;
    setMask[4] = rxValid && rxBreak;
  end

  always_ff @(posedge clk) begin
    if (!rstN) specStat <= '0;
    else       specStat <= (statClr ? '0 : specStat) | setMask;
  end

  // Injection character selection driven by control strobes
  always_comb begin
    if (ctl.kindOn) injData = ctl.pickFirst ? xonA  : xonB;
    else            injData = ctl.pickFirst ? xoffA : xoffB;
  end

endmodule

// File: rtl/xonxoff_flow_ctrl.sv
module xonxoff_flow_ctrl
  import xonxoff_flow_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        flowEn,
  input  logic [1:0]  rxSel,
  input  logic [1:0]  txSel,
  input  dp_flags_t   flags,
  input  logic        injAck,
  output logic        txPause,
  output logic        injReq,
  output ctl_strobe_t ctl
);

  inj_state_e state;
  logic       haltSent;
  logic       kindOn;
  logic [1:0] capSel;

  // Pause towards the local transmitter; stop wins over resume
  always_ff @(posedge clk) begin
    if (!rstN)                            txPause <= 1'b0;
    else if (!flowEn || rxSel == SEL_NONE) txPause <= 1'b0;
    else if (flags.xoffHit)               txPause <= 1'b1;
    else if (flags.xonHit)                txPause <= 1'b0;
  end

  // Injection sequencer with hysteresis flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= INJ_IDLE;
      haltSent <= 1'b0;
      kindOn   <= 1'b0;
      capSel   <= SEL_NONE;
    end else if (!flowEn || txSel == SEL_NONE) begin
      state    <= INJ_IDLE;
      haltSent <= 1'b0;
    end else begin
      unique case (state)
        INJ_IDLE: begin
          if (!haltSent && flags.levelHigh) begin
            state    <= INJ_FIRST;
            kindOn   <= 1'b0;
            haltSent <= 1'b1;
            capSel   <= txSel;
          end else if (haltSent && flags.levelLow) begin
            state    <= INJ_FIRST;
            kindOn   <= 1'b1;
            haltSent <= 1'b0;
            capSel   <= txSel;
          end
        end
        INJ_FIRST: begin
          if (injAck) state <= (capSel == SEL_BOTH) ? INJ_SECOND : INJ_IDLE;
        end
        INJ_SECOND: begin
          if (injAck) state <= INJ_IDLE;
        end
        default: state <= INJ_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.active    = (state != INJ_IDLE);
    ctl.kindOn    = kindOn;
    ctl.pickFirst = (capSel == SEL_FIRST) ||
                    ((capSel == SEL_BOTH) && (state == INJ_FIRST));
  end

  assign injReq = ctl.active;

endmodule

// File: rtl/xonxoff_flow.sv
module xonxoff_flow
  import xonxoff_flow_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 128,
  parameter int THR_W      = 4,
  parameter int LVL_UNIT   = 8,
  parameter int STAT_W     = 5,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                flowEn,
  input  logic [1:0]          rxSel,
  input  logic [1:0]          txSel,
  input  logic [DATA_W-1:0]   xonA,
  input  logic [DATA_W-1:0]   xonB,
  input  logic [DATA_W-1:0]   xoffA,
  input  logic [DATA_W-1:0]   xoffB,
  input  logic [2*THR_W-1:0]  levelCfg,
  input  logic                rxValid,
  input  logic [DATA_W-1:0]   rxData,
  input  logic                rxBreak,
  input  logic [LVL_W-1:0]    rxLevel,
  output logic                fwdValid,
  output logic [DATA_W-1:0]   fwdData,
  output logic                txPause,
  output logic                injReq,
  output logic [DATA_W-1:0]   injData,
  input  logic                injAck,
  input  logic                statClr,
  output logic [STAT_W-1:0]   specStat
);

  dp_flags_t   flags;
  ctl_strobe_t ctl;

  xonxoff_flow_dp #(
    .DATA_W(DATA_W), .LVL_W(LVL_W), .THR_W(THR_W),
    .LVL_UNIT(LVL_UNIT), .STAT_W(STAT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .flowEn(flowEn), .rxSel(rxSel),
    .xonA(xonA), .xonB(xonB), .xoffA(xoffA), .xoffB(xoffB),
    .levelCfg(levelCfg), .rxValid(rxValid), .rxData(rxData),
    .rxBreak(rxBreak), .rxLevel(rxLevel), .statClr(statClr),
    .ctl(ctl), .flags(flags), .fwdValid(fwdValid), .fwdData(fwdData),
    .injData(injData), .specStat(specStat)
  );

  xonxoff_flow_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .flowEn(flowEn), .rxSel(rxSel),
    .txSel(txSel), .flags(flags), .injAck(injAck),
    .txPause(txPause), .injReq(injReq), .ctl(ctl)
  );

endmodule

// File: rtl/xonxoff_flow_chk.sv
module xonxoff_flow_chk #(
  parameter int DATA_W = 8,
  parameter int STAT_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              flowEn,
  input logic [1:0]        rxSel,
  input logic [DATA_W-1:0] xoffA,
  input logic              rxValid,
  input logic [DATA_W-1:0] rxData,
  input logic              fwdValid,
  input logic [DATA_W-1:0] fwdData,
  input logic              txPause,
  input logic              injReq,
  input logic [DATA_W-1:0] injData,
  input logic              injAck,
  input logic              statClr,
  input logic [STAT_W-1:0] specStat
);

  // R9
  inj_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (injReq && !injAck && flowEn) |=> (injReq && $stable(injData)));

  // R3
  xoff_pause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && flowEn && rxSel == 2'b10 && rxData == xoffA) |=> txPause);

  // R6
  dis_pause_chk: assert property (@(posedge clk) disable iff (!rstN)
    !flowEn |=> (!txPause && !injReq));

  // R4
  dis_fwd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !flowEn) |=> (fwdValid && fwdData == $past(rxData)));

  // R5
  stat_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statClr && !rxValid) |=> (specStat == '0));

endmodule

bind xonxoff_flow xonxoff_flow_chk #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_chk (
  .clk(clk), .rstN(rstN), .flowEn(flowEn), .rxSel(rxSel), .xoffA(xoffA),
  .rxValid(rxValid), .rxData(rxData), .fwdValid(fwdValid), .fwdData(fwdData),
  .txPause(txPause), .injReq(injReq), .injData(injData), .injAck(injAck),
  .statClr(statClr), .specStat(specStat)
);

// File: tb/xonxoff_flow_bench.sv
module xonxoff_flow_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       flowEn = 1'b0;
  logic [1:0] rxSel = 2'b00, txSel = 2'b00;
  logic [7:0] xonA = 8'h11, xonB = 8'h21, xoffA = 8'h13, xoffB = 8'h23;
  logic [7:0] levelCfg = 8'h24; // resume 2 (16 words), halt 4 (32 words)
  logic       rxValid = 1'b0, rxBreak = 1'b0, statClr = 1'b0, injAck = 1'b0;
  logic [7:0] rxData = 8'h00, rxLevel = 8'd0;
  logic       fwdValid, txPause, injReq;
  logic [7:0] fwdData, injData;
  logic [4:0] specStat;

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] fwdQ[$];
  logic [7:0] injQ[$];

  always #2.5 clk = ~clk;

  xonxoff_flow u_xonxoff_flow (
    .clk(clk), .rstN(rstN), .flowEn(flowEn), .rxSel(rxSel), .txSel(txSel),
    .xonA(xonA), .xonB(xonB), .xoffA(xoffA), .xoffB(xoffB),
    .levelCfg(levelCfg), .rxValid(rxValid), .rxData(rxData), .rxBreak(rxBreak),
    .rxLevel(rxLevel), .fwdValid(fwdValid), .fwdData(fwdData), .txPause(txPause),
    .injReq(injReq), .injData(injData), .injAck(injAck), .statClr(statClr),
    .specStat(specStat)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Driver: one character, expected forwarding pushed to scoreboard
  task automatic sendChar(input logic [7:0] d, input bit brk, input bit clr, input bit fwd);
    @(negedge clk);
    rxValid = 1'b1; rxData = d; rxBreak = brk; statClr = clr;
    if (fwd) fwdQ.push_back(d);
    @(negedge clk);
    rxValid = 1'b0; rxBreak = 1'b0; statClr = 1'b0;
  endtask

  task automatic setLevel(input logic [7:0] lvl);
    @(negedge clk);
    rxLevel = lvl;
  endtask

  task automatic injDone(input string tag);
    repeat (30) @(negedge clk);
    check(injQ.size() == 0, tag, injQ.size(), 0);
    check(injReq == 1'b0, tag, injReq, 0);
  endtask

  // Monitor: forwarded characters
  always @(negedge clk) begin
    if (rstN && fwdValid) begin
      if (fwdQ.size() == 0) check(1'b0, "R4 unexpected forward", fwdData, 0);
      else begin
        logic [7:0] e;
        e = fwdQ.pop_front();
        check(fwdData == e, "R4 forwarded data", fwdData, e);
      end
    end
  end

  // Monitor: injection handshake, acks every other cycle
  always @(negedge clk) begin
    if (injAck) injAck = 1'b0;
    else if (rstN && injReq) begin
      if (injQ.size() == 0) check(1'b0, "R10 unexpected inject", injData, 0);
      else begin
        logic [7:0] e;
        e = injQ.pop_front();
        check(injData == e, "R8 injected char", injData, e);
      end
      injAck = 1'b1;
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(txPause == 0 && injReq == 0 && fwdValid == 0 && specStat == 0,
          "R1 reset state", {txPause, injReq, fwdValid, specStat}, 0);
    rstN = 1'b1;

    // R6: disabled, stop char forwarded, no effect
    rxSel = 2'b11;
    sendChar(8'h13, 0, 0, 1);
    check(txPause == 0, "R6 pause while disabled", txPause, 0);
    check(specStat == 0, "R6 status while disabled", specStat, 0);

    flowEn = 1'b1;
    // R2: second pair only
    rxSel = 2'b01;
    sendChar(8'h13, 0, 0, 1);
    check(txPause == 0, "R2 first-pair stop ignored with 01", txPause, 0);
    sendChar(8'h23, 0, 0, 0);
    check(txPause == 1, "R3 second stop sets pause", txPause, 1);
    check(specStat == 5'b01000, "R5 bit3 second stop", specStat, 5'b01000);
    sendChar(8'h11, 0, 0, 1);
    check(txPause == 1, "R2 first-pair resume ignored with 01", txPause, 1);
    sendChar(8'h21, 0, 0, 0);
    check(txPause == 0, "R3 second resume clears pause", txPause, 0);

    // R2: first pair only
    rxSel = 2'b10;
    sendChar(8'h23, 0, 0, 1);
    check(txPause == 0, "R2 second-pair stop ignored with 10", txPause, 0);
    sendChar(8'h13, 0, 0, 0);
    check(txPause == 1, "R3 first stop sets pause", txPause, 1);
    sendChar(8'h11, 0, 0, 0);
    check(txPause == 0, "R3 first resume clears pause", txPause, 0);

    // R2: all four
    rxSel = 2'b11;
    sendChar(8'h23, 0, 0, 0);
    check(txPause == 1, "R2 all four, second stop", txPause, 1);
    sendChar(8'h41, 0, 0, 1);
    check(txPause == 1, "R2 plain char keeps pause", txPause, 1);
    sendChar(8'h11, 0, 0, 0);
    check(txPause == 0, "R2 all four, first resume", txPause, 0);
    check(specStat == 5'b01111, "R5 four flow bits", specStat, 5'b01111);

    // R5: break, clear, set during clear
    sendChar(8'h00, 1, 0, 1);
    check(specStat == 5'b11111, "R5 break bit4", specStat, 5'b11111);
    sendChar(8'h21, 0, 1, 0);
    check(specStat == 5'b00010, "R5 set survives clear", specStat, 5'b00010);
    @(negedge clk); statClr = 1'b1;
    @(negedge clk); statClr = 1'b0;
    check(specStat == 0, "R5 clear", specStat, 0);

    // R2: selector 00
    rxSel = 2'b00;
    sendChar(8'h13, 0, 0, 1);
    check(txPause == 0, "R2 selector 00 no match", txPause, 0);
    check(specStat == 0, "R2 selector 00 no status", specStat, 0);

    // R7/R8: first pair
    txSel = 2'b10;
    injQ.push_back(8'h13);
    setLevel(8'd40);
    injDone("R7 stop above halt");
    setLevel(8'd128);
    injDone("R10 no second stop");
    injQ.push_back(8'h11);
    setLevel(8'd10);
    injDone("R7 resume below threshold");
    setLevel(8'd20);
    injDone("R10 no second resume");
    injQ.push_back(8'h13);
    setLevel(8'd32);
    injDone("R7 halt boundary");
    setLevel(8'd17);
    injDone("R7 above resume boundary");
    injQ.push_back(8'h11);
    setLevel(8'd16);
    injDone("R7 resume boundary");

    // R8: second pair
    txSel = 2'b01;
    setLevel(8'd31);
    injDone("R7 below halt boundary");
    injQ.push_back(8'h23);
    setLevel(8'd32);
    injDone("R8 second pair stop");
    injQ.push_back(8'h21);
    setLevel(8'd0);
    injDone("R8 second pair resume");

    // R8/R9: both pairs in order
    txSel = 2'b11;
    injQ.push_back(8'h13); injQ.push_back(8'h23);
    setLevel(8'd64);
    injDone("R9 stop pair order");
    injQ.push_back(8'h11); injQ.push_back(8'h21);
    setLevel(8'd8);
    injDone("R9 resume pair order");

    // R6: disable with level high
    flowEn = 1'b0;
    setLevel(8'd100);
    injDone("R6 no request while disabled");
    check(fwdQ.size() == 0, "R4 all forwards seen", fwdQ.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule